// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Controller

This block is the home-node directory engine for a small distributed shared memory. For every memory block it keeps one packed entry: a two-bit block state, a small fixed set of remote-sharer pointers, a bit for the home node's own cached copy, and bookkeeping for an open transaction. Requests arrive one per cycle, each tagged with a source node ID and a block address. A request is a read, a write, an invalidation acknowledgment or an owner update. One cycle later the block answers with a single reply message, a multicast invalidation, or nothing.

The hardware pointer set is deliberately small. When a new reader would need a sixth pointer, the controller does not evict anyone. It marks the entry as software-extended and raises a level interrupt that carries the block address, the request and the entry. From then on, every request to that block goes to software. A software handler hands a block back by pulsing a resume strobe together with a freshly written entry.

Top module: `lptr_dir_ctrl`

## Requirements
- R1: After reset every entry reads as Read-Only (state code 0) with no sharers, and `msg_valid`, `inv_valid` and `trap_irq` are low.
- R2: A read from node s to a Read-Only block replies RDATA (msg code 0) to s the next cycle. A non-sharer is appended as a pointer. The home node sets the local bit and uses no pointer. A node that is already a sharer is not added twice.
- R3: A read from a new remote node when all NPTR pointers are in use sends no message. It sets the software flag and raises `trap_irq` the next cycle, with `trap_addr`, `trap_src` and `trap_kind` taken from the request.
- R4: A write from s to a Read-Only or Read-Write block whose only holder is s, or that has no holder, moves the block to Read-Write with s as the only holder. It replies WDATA (msg code 1) to s.
- R5: A write to a block with holders other than the requester emits one `inv_valid` pulse. The pulse has a `inv_mask` bit for each pointer slot holding another node, with that node in the slot's `inv_ptrs` field, and `inv_local` set if the home node holds a copy and is not the requester. The block enters Write-Transaction (code 3) and no reply is sent.
- R6: In Write-Transaction each acknowledgment decrements the outstanding count, which starts at the number of invalidations sent. The last acknowledgment sends WDATA to the waiting writer and leaves the block Read-Write with that writer as holder. Earlier acknowledgments produce no output.
- R7: A read by a non-owner of a Read-Write block sends UPDREQ (msg code 3) to the owner and enters Read-Transaction (code 2). The owner may be the home node. The following owner update sends RDATA to the waiting reader, and the block returns to Read-Only with the reader as sole sharer.
- R8: A read or write to a block in Read-Transaction or Write-Transaction is answered BUSY (msg code 2) and leaves the entry unchanged.
- R9: Any request to a block whose software flag is set, while no trap is pending, raises a trap for that request and performs no hardware transition or reply.
- R10: `trap_irq` stays high until `sw_resume` is pulsed and falls the cycle after it. The resume writes `sw_entry` into entry `sw_addr`. A request presented in a resume cycle is answered BUSY and otherwise dropped. A request that would trap while a trap is pending is answered BUSY.
- R11: An acknowledgment or update that the block's state does not expect is ignored: no message, no invalidation, no entry change.
- R12: Entry layout with default parameters, as seen on `trap_entry` and `sw_entry`: [1:0] state, [2] software flag, [3] local bit, [6:4] pointer count, [51:7] pointers (slot k at 7+9k), [60:52] waiting node, [63:61] outstanding acknowledgments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 acknowledgment, 3 owner update |
| req_src | input | NODE_W | Source node of the request |
| req_addr | input | AW | Block index |
| sw_resume | input | 1 | Software hand-back strobe |
| sw_addr | input | AW | Block written by the hand-back |
| sw_entry | input | ENTRY_W | New entry value for the hand-back |
| msg_valid | output | 1 | Reply message valid |
| msg_kind | output | 2 | 0 RDATA, 1 WDATA, 2 BUSY, 3 UPDREQ |
| msg_dest | output | NODE_W | Destination node of the reply |
| inv_valid | output | 1 | Multicast invalidation valid |
| inv_mask | output | NPTR | Pointer slots to invalidate |
| inv_ptrs | output | NPTR*NODE_W | Node ID held in each pointer slot |
| inv_local | output | 1 | Invalidate the home node's copy |
| trap_irq | output | 1 | Level interrupt to the local processor |
| trap_addr | output | AW | Block that trapped |
| trap_src | output | NODE_W | Source of the trapping request |
| trap_kind | output | 2 | Kind of the trapping request |
| trap_entry | output | ENTRY_W | Entry value at the time of the trap |

## Verification
A corrupted pointer count or sharer slot shows up one cycle after the next write to that block. The multicast then carries the wrong mask, slot contents or local bit. A count that drifted upward also causes a premature or missing trap at the next new reader. A wrong transaction state or acknowledgment count surfaces at the next request to the block: a BUSY that should be a grant or the reverse, or a WDATA released one acknowledgment early or late. A stuck or dropped trap level is visible on `trap_irq` the cycle after the resume strobe.

// File: rtl/lptr_dir_pkg.sv
package lptr_dir_pkg;

   typedef enum logic [1:0] {
      ST_RO = 2'd0,
      ST_RW = 2'd1,
      ST_RT = 2'd2,
      ST_WT = 2'd3
   } blk_state_e;

   typedef enum logic [1:0] {
      RQ_RD  = 2'd0,
      RQ_WR  = 2'd1,
      RQ_ACK = 2'd2,
      RQ_UPD = 2'd3
   } req_kind_e;

   typedef enum logic [1:0] {
      MS_RDATA  = 2'd0,
      MS_WDATA  = 2'd1,
      MS_BUSY   = 2'd2,
      MS_UPDREQ = 2'd3
   } msg_kind_e;

endpackage

// File: rtl/lptr_dir_store.sv
module lptr_dir_store #(
   parameter int ENTRY_W = 64,
   parameter int NBLK    = 16,
   localparam int AW     = $clog2(NBLK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      rd_addr,
   output logic [ENTRY_W-1:0] rd_entry,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [ENTRY_W-1:0] wr_entry
);

   logic [ENTRY_W-1:0] mem [NBLK];

   // all-zero entry decodes as Read-Only with no holders
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBLK; b++) mem[b] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_entry;
      end
   end

   assign rd_entry = mem[rd_addr];

endmodule

// File: rtl/lptr_dir_sharers.sv
module lptr_dir_sharers #(
   parameter int NODE_W = 9,
   parameter int NPTR   = 5,
   localparam int CNT_W = $clog2(NPTR + 1),
   localparam int ACK_W = $clog2(NPTR + 2)
) (
   input  logic [NPTR*NODE_W-1:0] ptrs,
   input  logic [CNT_W-1:0]       cnt,
   input  logic                   loc,
   input  logic [NODE_W-1:0]      src,
   input  logic                   src_home,
   output logic                   is_member,
   output logic [NPTR-1:0]        oth_mask,
   output logic                   oth_local,
   output logic [ACK_W-1:0]       oth_num
);

   logic [NPTR-1:0] hit;

   for (genvar p = 0; p < NPTR; p++) begin : g_slot
      logic live;
      assign live        = CNT_W'(p) < cnt;
      assign hit[p]      = live && (ptrs[p*NODE_W +: NODE_W] == src);
      assign oth_mask[p] = live && !hit[p];
   end

   assign is_member = src_home ? loc : |hit;
   assign oth_local = loc && !src_home;

   always_comb begin
      oth_num = ACK_W'(oth_local);
      for (int p = 0; p < NPTR; p++) oth_num = oth_num + ACK_W'(oth_mask[p]);
   end

endmodule

// File: rtl/lptr_dir_ctrl.sv
module lptr_dir_ctrl
   import lptr_dir_pkg::*;
#(
   parameter int          NODE_W  = 9,
   parameter int          NPTR    = 5,
   parameter int          NBLK    = 16,
   parameter int          ENTRY_W = 64,
   parameter int unsigned HOME_ID = 0,
   localparam int         AW      = $clog2(NBLK)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [1:0]             req_kind,
   input  logic [NODE_W-1:0]      req_src,
   input  logic [AW-1:0]          req_addr,
   input  logic                   sw_resume,
   input  logic [AW-1:0]          sw_addr,
   input  logic [ENTRY_W-1:0]     sw_entry,
   output logic                   msg_valid,
   output logic [1:0]             msg_kind,
   output logic [NODE_W-1:0]      msg_dest,
   output logic                   inv_valid,
   output logic [NPTR-1:0]        inv_mask,
   output logic [NPTR*NODE_W-1:0] inv_ptrs,
   output logic                   inv_local,
   output logic                   trap_irq,
   output logic [AW-1:0]          trap_addr,
   output logic [NODE_W-1:0]      trap_src,
   output logic [1:0]             trap_kind,
   output logic [ENTRY_W-1:0]     trap_entry
);

   localparam int CNT_W  = $clog2(NPTR + 1);
   localparam int ACK_W  = $clog2(NPTR + 2);
   localparam int F_ST   = 0;
   localparam int F_FLAG = 2;
   localparam int F_LOC  = 3;
   localparam int F_CNT  = 4;
   localparam int F_PTR  = F_CNT + CNT_W;
   localparam int F_PEND = F_PTR + NPTR * NODE_W;
   localparam int F_ACK  = F_PEND + NODE_W;
   localparam int USED   = F_ACK + ACK_W;
   localparam logic [NODE_W-1:0] HOME = NODE_W'(HOME_ID);

   if (USED > ENTRY_W) begin : g_bad_width
      $error("ENTRY_W too small for the pointer set");
   end
   if (NBLK < 2) begin : g_bad_depth
      $error("NBLK must be at least 2");
   end
   if (HOME_ID >= (1 << NODE_W)) begin : g_bad_home
      $error("HOME_ID does not fit in NODE_W");
   end

   logic [ENTRY_W-1:0] cur, n;
   logic               wr_en;
   logic [AW-1:0]      wr_addr;

   lptr_dir_store #(.ENTRY_W(ENTRY_W), .NBLK(NBLK)) store_i (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(req_addr), .rd_entry(cur),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_entry(n)
   );

   blk_state_e            c_state;
   req_kind_e             rk;
   logic [1:0]            c_st_bits;
   logic                  c_flag, c_loc, src_home;
   logic [CNT_W-1:0]      c_cnt;
   logic [NPTR*NODE_W-1:0] c_ptrs;
   logic [NODE_W-1:0]     c_pend, owner_id;
   logic [ACK_W-1:0]      c_ack;

   assign c_st_bits = cur[F_ST +: 2];
   assign c_state   = blk_state_e'(c_st_bits);
   assign rk        = req_kind_e'(req_kind);
   assign c_flag    = cur[F_FLAG];
   assign c_loc     = cur[F_LOC];
   assign c_cnt     = cur[F_CNT +: CNT_W];
   assign c_ptrs    = cur[F_PTR +: NPTR*NODE_W];
   assign c_pend    = cur[F_PEND +: NODE_W];
   assign c_ack     = cur[F_ACK +: ACK_W];
   assign src_home  = (req_src == HOME);
   assign owner_id  = c_loc ? HOME : c_ptrs[NODE_W-1:0];

   logic                  is_member, oth_local;
   logic [NPTR-1:0]       oth_mask;
   logic [ACK_W-1:0]      oth_num;

   lptr_dir_sharers #(.NODE_W(NODE_W), .NPTR(NPTR)) sharers_i (
      .ptrs(c_ptrs), .cnt(c_cnt), .loc(c_loc), .src(req_src), .src_home(src_home),
      .is_member(is_member), .oth_mask(oth_mask), .oth_local(oth_local), .oth_num(oth_num)
   );

   // entry rewritten with a single holder
   function automatic logic [ENTRY_W-1:0] set_single(input logic [ENTRY_W-1:0] e,
                                                     input logic [NODE_W-1:0] who);
      logic [ENTRY_W-1:0] r;
      r = e;
      r[F_PTR +: NPTR*NODE_W] = '0;
      if (who == HOME) begin
         r[F_LOC]           = 1'b1;
         r[F_CNT +: CNT_W]  = '0;
      end else begin
         r[F_LOC]           = 1'b0;
         r[F_CNT +: CNT_W]  = CNT_W'(1);
         r[F_PTR +: NODE_W] = who;
      end
      return r;
   endfunction

   logic              nx_mv, nx_iv, nx_trap;
   msg_kind_e         nx_mk;
   logic [NODE_W-1:0] nx_md;

   always_comb begin
      n       = cur;
      wr_en   = 1'b0;
      wr_addr = req_addr;
      nx_mv   = 1'b0;
      nx_mk   = MS_BUSY;
      nx_md   = req_src;
      nx_iv   = 1'b0;
      nx_trap = 1'b0;
      if (sw_resume) begin
         wr_en   = 1'b1;
         wr_addr = sw_addr;
         n       = sw_entry;
         nx_mv   = req_valid;
      end else if (req_valid) begin
         wr_en = 1'b1;
         if (c_flag) begin
            if (trap_irq) nx_mv = 1'b1;
            else          nx_trap = 1'b1;
         end else begin
            case (c_state)
               ST_RO, ST_RW: begin
                  if (rk == RQ_RD) begin
                     if (is_member) begin
                        nx_mv = 1'b1;
                        nx_mk = MS_RDATA;
                     end else if (c_state == ST_RW) begin
                        nx_mv = 1'b1;
                        nx_mk = MS_UPDREQ;
                        nx_md = owner_id;
                        n[F_ST +: 2]        = ST_RT;
                        n[F_PEND +: NODE_W] = req_src;
                     end else if (src_home) begin
                        n[F_LOC] = 1'b1;
                        nx_mv    = 1'b1;
                        nx_mk    = MS_RDATA;
                     end else if (c_cnt < CNT_W'(NPTR)) begin
                        n[F_PTR + int'(c_cnt) * NODE_W +: NODE_W] = req_src;
                        n[F_CNT +: CNT_W] = c_cnt + CNT_W'(1);
                        nx_mv = 1'b1;
                        nx_mk = MS_RDATA;
                     end else if (!trap_irq) begin
                        n[F_FLAG] = 1'b1;
                        nx_trap   = 1'b1;
                     end else begin
                        nx_mv = 1'b1;
                     end
                  end else if (rk == RQ_WR) begin
                     if (oth_num == '0) begin
                        n            = set_single(cur, req_src);
                        n[F_ST +: 2] = ST_RW;
                        nx_mv        = 1'b1;
                        nx_mk        = MS_WDATA;
                     end else begin
                        nx_iv               = 1'b1;
                        n[F_ST +: 2]        = ST_WT;
                        n[F_PEND +: NODE_W] = req_src;
                        n[F_ACK +: ACK_W]   = oth_num;
                        n[F_LOC]            = 1'b0;
                        n[F_CNT +: CNT_W]   = '0;
                     end
                  end
               end
               default: begin
                  if (!req_kind[1]) begin
                     nx_mv = 1'b1;
                  end else if (c_state == ST_WT && rk == RQ_ACK) begin
                     if (c_ack == ACK_W'(1)) begin
                        n                 = set_single(cur, c_pend);
                        n[F_ST +: 2]      = ST_RW;
                        n[F_ACK +: ACK_W] = '0;
                        nx_mv = 1'b1;
                        nx_mk = MS_WDATA;
                        nx_md = c_pend;
                     end else begin
                        n[F_ACK +: ACK_W] = c_ack - ACK_W'(1);
                     end
                  end else if (c_state == ST_RT && rk == RQ_UPD) begin
                     n            = set_single(cur, c_pend);
                     n[F_ST +: 2] = ST_RO;
                     nx_mv = 1'b1;
                     nx_mk = MS_RDATA;
                     nx_md = c_pend;
                  end
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         msg_kind   <= '0;
         msg_dest   <= '0;
         inv_valid  <= 1'b0;
         inv_mask   <= '0;
         inv_ptrs   <= '0;
         inv_local  <= 1'b0;
         trap_irq   <= 1'b0;
         trap_addr  <= '0;
         trap_src   <= '0;
         trap_kind  <= '0;
         trap_entry <= '0;
      end else begin
         msg_valid <= nx_mv;
         msg_kind  <= nx_mk;
         msg_dest  <= nx_md;
         inv_valid <= nx_iv;
         inv_mask  <= oth_mask;
         inv_ptrs  <= c_ptrs;
         inv_local <= oth_local;
         if (sw_resume) begin
            trap_irq <= 1'b0;
         end else if (nx_trap) begin
            trap_irq   <= 1'b1;
            trap_addr  <= req_addr;
            trap_src   <= req_src;
            trap_kind  <= req_kind;
            trap_entry <= n;
         end
      end
   end

endmodule

// File: rtl/lptr_dir_chk.sv
module lptr_dir_chk #(
   parameter int NPTR  = 5,
   parameter int ACK_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_kind,
   input logic             sw_resume,
   input logic             msg_valid,
   input logic [1:0]       msg_kind,
   input logic             inv_valid,
   input logic [NPTR-1:0]  inv_mask,
   input logic             inv_local,
   input logic             trap_irq,
   input logic [1:0]       cur_state,
   input logic             cur_flag,
   input logic [ACK_W-1:0] cur_ack
);

   p_busy_txn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !sw_resume && !cur_flag && cur_state[1] && !req_kind[1])
      |=> (msg_valid && msg_kind == 2'd2));

   p_irq_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trap_irq) |-> $past(sw_resume));

   p_resume_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_resume && req_valid) |=> (msg_valid && msg_kind == 2'd2 && !inv_valid));

   p_single_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({msg_valid, inv_valid}));

   p_inv_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> ((|inv_mask) || inv_local));

   p_ack_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cur_flag && cur_state == 2'd3) |-> (cur_ack != '0));

   p_trap_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trap_irq) |-> (!msg_valid && !inv_valid));

endmodule

bind lptr_dir_ctrl lptr_dir_chk #(.NPTR(NPTR), .ACK_W(ACK_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
   .sw_resume(sw_resume), .msg_valid(msg_valid), .msg_kind(msg_kind),
   .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_local(inv_local),
   .trap_irq(trap_irq), .cur_state(c_st_bits), .cur_flag(c_flag), .cur_ack(c_ack)
);

// File: tb/lptr_dir_ctrl_tb_top.sv
module lptr_dir_ctrl_tb_top;

   localparam int NB   = 16;
   localparam int NP   = 5;
   localparam int HOME = 0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [8:0]  req_src = '0;
   logic [3:0]  req_addr = '0;
   logic        sw_resume = 1'b0;
   logic [3:0]  sw_addr = '0;
   logic [63:0] sw_entry = '0;
   logic        msg_valid;
   logic [1:0]  msg_kind;
   logic [8:0]  msg_dest;
   logic        inv_valid;
   logic [4:0]  inv_mask;
   logic [44:0] inv_ptrs;
   logic        inv_local;
   logic        trap_irq;
   logic [3:0]  trap_addr;
   logic [8:0]  trap_src;
   logic [1:0]  trap_kind;
   logic [63:0] trap_entry;

   always #4 clk = ~clk;

   lptr_dir_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_src(req_src), .req_addr(req_addr), .sw_resume(sw_resume),
      .sw_addr(sw_addr), .sw_entry(sw_entry), .msg_valid(msg_valid),
      .msg_kind(msg_kind), .msg_dest(msg_dest), .inv_valid(inv_valid),
      .inv_mask(inv_mask), .inv_ptrs(inv_ptrs), .inv_local(inv_local),
      .trap_irq(trap_irq), .trap_addr(trap_addr), .trap_src(trap_src),
      .trap_kind(trap_kind), .trap_entry(trap_entry)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // behavioural model
   int m_st   [NB];
   bit m_flag [NB];
   bit m_loc  [NB];
   int m_sh   [NB][$];
   int m_pend [NB];
   int m_ack  [NB];
   bit m_irq;
   int m_taddr, m_tsrc, m_tkind, e_tst, e_tcnt;
   bit e_tflag;
   bit e_mv, e_iv, e_il;
   int e_mk, e_md;
   int e_inodes[$];
   string e_tag = "R1";

   function automatic bit in_q(int q[$], int v);
      foreach (q[i]) if (q[i] == v) return 1;
      return 0;
   endfunction

   function automatic logic [63:0] mk_entry(int st, bit fl, bit lc, int q[$]);
      logic [63:0] e = '0;
      e[1:0] = 2'(st);
      e[2]   = fl;
      e[3]   = lc;
      e[6:4] = 3'(q.size());
      foreach (q[i]) e[7 + 9*i +: 9] = 9'(q[i]);
      return e;
   endfunction

   task automatic set_single(int a, int x);
      m_sh[a].delete();
      m_loc[a] = (x == HOME);
      if (x != HOME) m_sh[a].push_back(x);
   endtask

   task automatic raise(int a, int s, int k, string tag);
      m_irq = 1; m_taddr = a; m_tsrc = s; m_tkind = k;
      e_tst = m_st[a]; e_tflag = m_flag[a]; e_tcnt = m_sh[a].size();
      e_tag = tag;
   endtask

   task automatic reply(int k, int d, string tag);
      e_mv = 1; e_mk = k; e_md = d; e_tag = tag;
   endtask

   task automatic step(bit v, int k, int s, int a, bit rs, int sa, logic [63:0] se);
      bit home;
      int oth[$];
      bit ol;
      e_mv = 0; e_iv = 0; e_il = 0; e_inodes.delete();
      e_tag = m_irq ? "R10" : "R11";
      if (rs) begin
         m_st[sa] = int'(se[1:0]); m_flag[sa] = se[2]; m_loc[sa] = se[3];
         m_sh[sa].delete();
         for (int i = 0; i < int'(se[6:4]); i++) m_sh[sa].push_back(int'(se[7 + 9*i +: 9]));
         m_pend[sa] = int'(se[60:52]); m_ack[sa] = int'(se[63:61]);
         m_irq = 0;
         if (v) reply(2, s, "R10");
         return;
      end
      if (!v) return;
      if (m_flag[a]) begin
         if (!m_irq) raise(a, s, k, "R9"); else reply(2, s, "R10");
         return;
      end
      home = (s == HOME);
      foreach (m_sh[a][i]) if (m_sh[a][i] != s) oth.push_back(m_sh[a][i]);
      ol = m_loc[a] && !home;
      if (m_st[a] <= 1) begin
         if (k == 0) begin
            if (home ? m_loc[a] : in_q(m_sh[a], s)) reply(0, s, "R2");
            else if (m_st[a] == 1) begin
               reply(3, m_loc[a] ? HOME : m_sh[a][0], "R7");
               m_st[a] = 2; m_pend[a] = s;
            end else if (home) begin m_loc[a] = 1; reply(0, s, "R2"); end
            else if (m_sh[a].size() < NP) begin m_sh[a].push_back(s); reply(0, s, "R2"); end
            else if (!m_irq) begin m_flag[a] = 1; raise(a, s, k, "R3"); end
            else reply(2, s, "R10");
         end else if (k == 1) begin
            if (oth.size() == 0 && !ol) begin
               set_single(a, s); m_st[a] = 1; reply(1, s, "R4");
            end else begin
               e_iv = 1; e_il = ol; e_inodes = oth; e_tag = "R5";
               m_st[a] = 3; m_pend[a] = s; m_ack[a] = oth.size() + int'(ol);
               m_sh[a].delete(); m_loc[a] = 0;
            end
         end
      end else begin
         if (k <= 1) reply(2, s, "R8");
         else if (m_st[a] == 3 && k == 2) begin
            e_tag = "R6";
            m_ack[a]--;
            if (m_ack[a] == 0) begin
               set_single(a, m_pend[a]); m_st[a] = 1; reply(1, m_pend[a], "R6");
            end
         end else if (m_st[a] == 2 && k == 3) begin
            set_single(a, m_pend[a]); m_st[a] = 0; reply(0, m_pend[a], "R7");
         end
      end
   endtask

   task automatic compare();
      int got[$];
      bit bad;
      checks++;
      if (msg_valid !== e_mv || (e_mv && (int'(msg_kind) != e_mk || int'(msg_dest) != e_md))) begin
         failures++;
         $display("FAIL %s msg actual v=%0b k=%0d d=%0d expected v=%0b k=%0d d=%0d",
                  e_tag, msg_valid, msg_kind, msg_dest, e_mv, e_mk, e_md);
      end
      checks++;
      bad = (inv_valid !== e_iv);
      if (e_iv) begin
         for (int p = 0; p < NP; p++) if (inv_mask[p]) got.push_back(int'(inv_ptrs[9*p +: 9]));
         if (inv_local !== e_il || got.size() != e_inodes.size()) bad = 1;
         else foreach (got[i]) if (got[i] != e_inodes[i]) bad = 1;
      end
      if (bad) begin
         failures++;
         $display("FAIL %s inv actual v=%0b local=%0b nodes=%p expected v=%0b local=%0b nodes=%p",
                  e_tag, inv_valid, inv_local, got, e_iv, e_il, e_inodes);
      end
      checks++;
      bad = (trap_irq !== m_irq);
      if (m_irq && !bad)
         bad = int'(trap_addr) != m_taddr || int'(trap_src) != m_tsrc ||
               int'(trap_kind) != m_tkind || int'(trap_entry[1:0]) != e_tst ||
               trap_entry[2] != e_tflag || int'(trap_entry[6:4]) != e_tcnt;
      if (bad) begin
         failures++;
         $display("FAIL %s R12 trap actual irq=%0b a=%0d s=%0d k=%0d st=%0d fl=%0b n=%0d expected irq=%0b a=%0d s=%0d k=%0d st=%0d fl=%0b n=%0d",
                  e_tag, trap_irq, trap_addr, trap_src, trap_kind, trap_entry[1:0], trap_entry[2],
                  trap_entry[6:4], m_irq, m_taddr, m_tsrc, m_tkind, e_tst, e_tflag, e_tcnt);
      end
   endtask

   task automatic cyc(bit v, int k, int s, int a, bit rs = 0, int sa = 0, logic [63:0] se = '0);
      @(negedge clk);
      compare();
      req_valid = v; req_kind = 2'(k); req_src = 9'(s); req_addr = 4'(a);
      sw_resume = rs; sw_addr = 4'(sa); sw_entry = se;
      step(v, k, s, a, rs, sa, se);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
   endtask

   initial begin
      int q[$];
      for (int b = 0; b < NB; b++) begin
         m_st[b] = 0; m_flag[b] = 0; m_loc[b] = 0; m_pend[b] = 0; m_ack[b] = 0;
      end
      m_irq = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);                         // R1 reset state
      // R2 reads, repeat reader, home local bit
      cyc(1, 0, 3, 1); cyc(1, 0, 3, 1); cyc(1, 0, HOME, 1);
      cyc(1, 0, 4, 1); cyc(1, 0, 5, 1); cyc(1, 0, 6, 1); cyc(1, 0, 7, 1);
      cyc(1, 0, 8, 1);                 // R3 overflow trap
      cyc(1, 0, 9, 1);                 // R10 busy while pending
      cyc(1, 0, 3, 2);                 // other block still served
      idle(3);                         // R10 level held
      q = {3, 4};
      cyc(1, 0, 5, 2, 1, 1, mk_entry(0, 0, 1, q)); // R10 resume, request busy
      idle(1);
      // R5 / R8 / R11 / R6 on block 1
      cyc(1, 1, 3, 1);
      cyc(1, 0, 5, 1); cyc(1, 1, 6, 1); cyc(1, 3, 6, 1);
      cyc(1, 2, 4, 1); cyc(1, 2, HOME, 1);
      // R7 owner paths
      cyc(1, 0, 3, 1); cyc(1, 1, 3, 1);
      cyc(1, 0, 7, 1); cyc(1, 0, 8, 1); cyc(1, 2, 8, 1); cyc(1, 3, 3, 1);
      cyc(1, 1, 7, 1);                 // R4 sole sharer
      // block 3: home as writer and owner
      cyc(1, 1, 10, 3); cyc(1, 1, HOME, 3); cyc(1, 2, 10, 3);
      cyc(1, 0, 11, 3); cyc(1, 3, HOME, 3);
      // block 4: R9 software-held block
      for (int i = 1; i <= 6; i++) cyc(1, 0, i, 4);
      idle(1);
      q = {1, 2, 3, 4, 5};
      cyc(0, 0, 0, 0, 1, 4, mk_entry(0, 1, 0, q));
      idle(1);
      cyc(1, 1, 1, 4);                 // R9 trap, no invalidation
      idle(2);
      q.delete();
      cyc(0, 0, 0, 0, 1, 4, mk_entry(0, 0, 0, q));
      cyc(1, 1, 1, 4);                 // R4 grant on empty block
      cyc(1, 2, 9, 5); cyc(1, 3, 9, 5); // R11 stray on idle block
      cyc(1, 0, 9, 5);
      idle(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule